// File: doc/BRIEF.md
# CSR Access Gate with Read-Modify-Write

This block stands between an instruction pipeline and a control/status register file. For every request it works out whether the access is allowed. It returns the register's previous contents, and for a legal access with a nonzero write mask it issues a single write strobe that carries the merged value. The register file provides the current contents of the addressed register, and it also signals whether that address is implemented and whether it is a floating-point status register. The gate does not decode register storage itself.

The legality decision combines several checks:

- **Privilege level from the address.** The level an address needs is encoded in the address itself.
- **Read-only address space.** One address region refuses any write.
- **User counter enables.** Counter addresses are gated by two enable registers, one per privilege layer, chained together.
- **Floating-point state.** Floating-point registers are refused while floating-point state is switched off. A debugger access bypasses this check.

All instruction forms reach the block through one (new value, mask) pair:

| Form | New value | Mask |
|---|---|---|
| Swap | operand | all ones |
| Set | all ones | operand |
| Clear | zero | operand |
| Plain read | any | zero |

The result of each request appears exactly one cycle after the request is presented. It comes out as a response valid, an illegal flag and the read data, together with the write strobe when there is one.

Top module: `csr_access_gate`

## Requirements
- R1: Privilege encoding is user=0, supervisor=1, machine=3. An access is illegal when the current privilege, taken as an unsigned number, is below address bits [9:8].
- R2: An address whose bits [11:10] are 2'b11 is read-only. Any access to it with a nonzero mask is illegal, while a zero-mask read of it is legal.
- R3: User counter addresses are 0xC00–0xC1F and 0xC80–0xC9F. For these, the enable word starts as all ones. Below machine level it is ANDed with the machine counter enable, and below supervisor level it is also ANDed with the supervisor counter enable. The access is illegal unless bit addr[4:0] of the result is set.
- R4: A floating-point register access is illegal when the floating-point state field is 2'b00, unless the debug flag is set.
- R5: A legal floating-point register access with a nonzero mask pulses `fs_mark_dirty` in the same cycle as the write strobe, which tells the owner to set the state field to 2'b11.
- R6: The written value is (old AND NOT mask) OR (new AND mask). `wr_addr` is the request address.
- R7: A request with a zero mask produces no write strobe and no dirty pulse.
- R8: An address that is not implemented is illegal. A legal access returns the old value in `rsp_rdata`. An illegal access returns zero and produces no write strobe.
- R9: `rsp_valid`, `rsp_illegal`, `rsp_rdata`, `wr_en`, `wr_data` and `fs_mark_dirty` reflect the request presented one clock earlier. A cycle with no request yields no response and no write.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| req_wdata | input | XLEN | New value |
| req_wmask | input | XLEN | Write mask |
| req_debug | input | 1 | Access comes from the debugger |
| fs_state | input | 2 | Floating-point state field |
| m_cnt_en | input | 32 | Machine counter enable register |
| s_cnt_en | input | 32 | Supervisor counter enable register |
| csr_present | input | 1 | Addressed register is implemented |
| csr_fp | input | 1 | Addressed register is a floating-point register |
| csr_old | input | XLEN | Current contents of the addressed register |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Access refused |
| rsp_rdata | output | XLEN | Previous value, zero when refused |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 12 | Write address |
| wr_data | output | XLEN | Merged value to write |
| fs_mark_dirty | output | 1 | Set floating-point state to dirty |

## Verification
The bench targets these corner cases, each with the failure a wrong design would show:

- **Privilege boundaries.** It probes addresses at every privilege boundary. A design that compares with the wrong sign or uses the wrong address bits would either let user code reach machine registers or lock machine code out.
- **Counter enable chain.** It exercises the counter window with enable patterns that differ between the two enable registers. This exposes a chain that applies the supervisor enable at supervisor level, or that ignores the machine enable at user level.
- **Floating-point gate.** It toggles the debug bypass with floating-point state off, and it sends zero-mask floating-point reads. A faulty gate would refuse debugger reads, or would mark the state dirty on a read.
- **Merge behaviour.** It runs partial masks and read-only reads. This catches a merge that drops the old bits and a read-only check that refuses plain reads.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_M = 2'd3
   } priv_e;

   localparam int ADDR_W   = 12;
   localparam int CNT_W    = 32;
   localparam int CNT_SEL_W = $clog2(CNT_W);

   // upper address bits of the two user counter windows
   localparam logic [ADDR_W-6:0] CTR_LO_PAGE = 7'h60;
   localparam logic [ADDR_W-6:0] CTR_HI_PAGE = 7'h64;

   typedef struct packed {
      logic priv_fail;
      logic ro_fail;
      logic absent_fail;
      logic ctr_fail;
      logic fp_fail;
   } deny_t;

endpackage

// File: rtl/csr_priv_check.sv
module csr_priv_check
   import csr_gate_pkg::*;
(
   input  logic [3:0] addr_hi,
   input  logic [1:0] priv,
   input  logic       wmask_nz,
   input  logic       present,
   output logic       priv_fail,
   output logic       ro_fail,
   output logic       absent_fail
);
   logic [1:0] need_lvl;
   logic       ro_space;

   assign need_lvl    = addr_hi[1:0];
   assign ro_space    = (addr_hi[3:2] == 2'b11);
   assign priv_fail   = (priv < need_lvl);
   assign ro_fail     = ro_space & wmask_nz;
   assign absent_fail = ~present;
endmodule

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
   import csr_gate_pkg::*;
#(
   parameter int  EN_W           = 32,
   parameter bit  HAS_SUPERVISOR = 1'b1
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   input  logic [EN_W-1:0]   m_en,
   input  logic [EN_W-1:0]   s_en,
   output logic              ctr_fail
);
   localparam int SEL_W = $clog2(EN_W);

   logic              in_window;
   logic [EN_W-1:0]   chain;
   logic [SEL_W-1:0]  sel;

   generate
      if (EN_W != 32) begin : g_bad_width
         $error("csr_counter_gate: EN_W must be 32");
      end
   endgenerate

   assign in_window = (addr[ADDR_W-1:5] == CTR_LO_PAGE) |
                      (addr[ADDR_W-1:5] == CTR_HI_PAGE);
   assign sel = addr[SEL_W-1:0];

   generate
      if (HAS_SUPERVISOR) begin : g_two_layer
         always_comb begin
            chain = '1;
            if (priv < PRIV_M) chain = chain & m_en;
            if (priv < PRIV_S) chain = chain & s_en;
         end
      end else begin : g_one_layer
         logic unused_s;
         assign unused_s = ^s_en;
         always_comb begin
            chain = '1;
            if (priv < PRIV_M) chain = chain & m_en;
         end
      end
   endgenerate

   assign ctr_fail = in_window & ~chain[sel];
endmodule

// File: rtl/csr_fp_gate.sv
module csr_fp_gate (
   input  logic       is_fp,
   input  logic [1:0] fs,
   input  logic       debug,
   output logic       fp_fail
);
   assign fp_fail = is_fp & (fs == 2'b00) & ~debug;
endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge #(
   parameter int XLEN = 32
)(
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] new_val,
   input  logic [XLEN-1:0] mask,
   output logic [XLEN-1:0] merged
);
   generate
      for (genvar b = 0; b < XLEN; b++) begin : g_bit
         assign merged[b] = mask[b] ? new_val[b] : old_val[b];
      end
   endgenerate
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
   import csr_gate_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter bit HAS_SUPERVISOR = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [1:0]          req_priv,
   input  logic [XLEN-1:0]     req_wdata,
   input  logic [XLEN-1:0]     req_wmask,
   input  logic                req_debug,
   input  logic [1:0]          fs_state,
   input  logic [CNT_W-1:0]    m_cnt_en,
   input  logic [CNT_W-1:0]    s_cnt_en,
   input  logic                csr_present,
   input  logic                csr_fp,
   input  logic [XLEN-1:0]     csr_old,
   output logic                rsp_valid,
   output logic                rsp_illegal,
   output logic [XLEN-1:0]     rsp_rdata,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [XLEN-1:0]     wr_data,
   output logic                fs_mark_dirty
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("csr_access_gate: XLEN must be 32 or 64");
      end
   endgenerate

   deny_t           deny;
   logic            wmask_nz;
   logic            refuse;
   logic            do_write;
   logic [XLEN-1:0] merged;

   assign wmask_nz = |req_wmask;

   csr_priv_check u_priv (
      .addr_hi     (req_addr[ADDR_W-1:8]),
      .priv        (req_priv),
      .wmask_nz    (wmask_nz),
      .present     (csr_present),
      .priv_fail   (deny.priv_fail),
      .ro_fail     (deny.ro_fail),
      .absent_fail (deny.absent_fail)
   );

   csr_counter_gate #(
      .EN_W           (CNT_W),
      .HAS_SUPERVISOR (HAS_SUPERVISOR)
   ) u_ctr (
      .addr     (req_addr),
      .priv     (req_priv),
      .m_en     (m_cnt_en),
      .s_en     (s_cnt_en),
      .ctr_fail (deny.ctr_fail)
   );

   csr_fp_gate u_fp (
      .is_fp   (csr_fp),
      .fs      (fs_state),
      .debug   (req_debug),
      .fp_fail (deny.fp_fail)
   );

   csr_rmw_merge #(.XLEN(XLEN)) u_merge (
      .old_val (csr_old),
      .new_val (req_wdata),
      .mask    (req_wmask),
      .merged  (merged)
   );

   assign refuse   = |deny;
   assign do_write = req_valid & ~refuse & wmask_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_illegal   <= 1'b0;
         rsp_rdata     <= '0;
         wr_en         <= 1'b0;
         wr_addr       <= '0;
         wr_data       <= '0;
         fs_mark_dirty <= 1'b0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_illegal   <= req_valid & refuse;
         rsp_rdata     <= (req_valid & ~refuse) ? csr_old : '0;
         wr_en         <= do_write;
         wr_addr       <= do_write ? req_addr : '0;
         wr_data       <= do_write ? merged : '0;
         fs_mark_dirty <= do_write & csr_fp;
      end
   end

   // R9: one response per request, one cycle later
   a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r9_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !wr_en);
   // R8: a refused access never writes and returns zero
   a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> !wr_en && rsp_rdata == '0);
   a_r8_absent_refused: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !csr_present |=> rsp_illegal);
   // R2: writes into the read-only space are refused
   a_r2_ro_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr[11:10] == 2'b11 && req_wmask != '0 |=> rsp_illegal);
   // R7: zero mask never writes
   a_r7_zero_mask_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_wmask == '0 |=> !wr_en && !fs_mark_dirty);
   // R5: dirty pulse only accompanies a write
   a_r5_dirty_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      fs_mark_dirty |-> wr_en);
   // R1: machine-level address refused from user level
   a_r1_user_to_machine: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_priv == 2'd0 && req_addr[9:8] == 2'b11 |=> rsp_illegal);
endmodule

// File: tb/test_csr_access_gate.sv
`timescale 1ns/1ps
module test_csr_access_gate;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [11:0]     req_addr = '0;
   logic [1:0]      req_priv = '0;
   logic [XLEN-1:0] req_wdata = '0;
   logic [XLEN-1:0] req_wmask = '0;
   logic            req_debug = 1'b0;
   logic [1:0]      fs_state = '0;
   logic [31:0]     m_cnt_en = '0;
   logic [31:0]     s_cnt_en = '0;
   logic            csr_present = 1'b0;
   logic            csr_fp = 1'b0;
   logic [XLEN-1:0] csr_old = '0;
   logic            rsp_valid, rsp_illegal, wr_en, fs_mark_dirty;
   logic [XLEN-1:0] rsp_rdata, wr_data;
   logic [11:0]     wr_addr;

   int n_checks = 0;
   int n_fail = 0;
   bit running = 1'b1;

   always #2.5 clk = ~clk;

   csr_access_gate #(.XLEN(XLEN)) i_csr_access_gate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_priv(req_priv), .req_wdata(req_wdata), .req_wmask(req_wmask),
      .req_debug(req_debug), .fs_state(fs_state), .m_cnt_en(m_cnt_en),
      .s_cnt_en(s_cnt_en), .csr_present(csr_present), .csr_fp(csr_fp),
      .csr_old(csr_old), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
      .rsp_rdata(rsp_rdata), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fs_mark_dirty(fs_mark_dirty));

   // reference model state: expected outputs for the next negedge
   logic            e_valid, e_illegal, e_wr, e_dirty;
   logic [XLEN-1:0] e_rdata, e_wdata;
   logic [11:0]     e_waddr;
   string           e_tag;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_illegal = 0; e_wr = 0; e_dirty = 0;
         e_rdata = 0; e_wdata = 0; e_waddr = 0; e_tag = "R10";
      end else begin
         logic [31:0] ena;
         logic        bad;
         int          a;
         a = req_addr;
         bad = 1'b0;
         e_tag = "R8";
         if (int'(req_priv) < ((a >> 8) & 3)) begin bad = 1; e_tag = "R1"; end
         else if (((a >> 10) & 3) == 3 && req_wmask != 0) begin bad = 1; e_tag = "R2"; end
         else if (!csr_present) begin bad = 1; e_tag = "R8"; end
         else if ((a >= 'hC00 && a <= 'hC1F) || (a >= 'hC80 && a <= 'hC9F)) begin
            ena = 32'hFFFF_FFFF;
            if (req_priv != 2'd3) ena = ena & m_cnt_en;
            if (req_priv == 2'd0) ena = ena & s_cnt_en;
            if (!ena[a % 32]) begin bad = 1; e_tag = "R3"; end
         end
         if (!bad && csr_fp && fs_state == 0 && !req_debug) begin bad = 1; e_tag = "R4"; end
         e_valid   = req_valid;
         e_illegal = req_valid && bad;
         e_rdata   = (req_valid && !bad) ? csr_old : 0;
         e_wr      = req_valid && !bad && req_wmask != 0;
         e_wdata   = e_wr ? ((csr_old & ~req_wmask) | (req_wdata & req_wmask)) : 0;
         e_waddr   = e_wr ? req_addr : 0;
         e_dirty   = e_wr && csr_fp;
      end
   end

   always @(negedge clk) begin
      if (running) begin
         chk("R9 rsp_valid", 64'(rsp_valid), 64'(e_valid));
         chk({e_tag, " rsp_illegal"}, 64'(rsp_illegal), 64'(e_illegal));
         chk("R8 rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
         chk("R7 wr_en", 64'(wr_en), 64'(e_wr));
         chk("R6 wr_data", 64'(wr_data), 64'(e_wdata));
         chk("R6 wr_addr", 64'(wr_addr), 64'(e_waddr));
         chk("R5 fs_mark_dirty", 64'(fs_mark_dirty), 64'(e_dirty));
      end
   end

   task automatic req(input logic [11:0] ad, input logic [1:0] pv, input logic [31:0] nv,
                      input logic [31:0] mk, input logic pres, input logic fp,
                      input logic dbg, input logic [1:0] fs, input logic [31:0] old);
      @(negedge clk);
      req_valid = 1; req_addr = ad; req_priv = pv; req_wdata = nv; req_wmask = mk;
      csr_present = pres; csr_fp = fp; req_debug = dbg; fs_state = fs; csr_old = old;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      running = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 rsp_valid", 64'(rsp_valid), 0);
      chk("R10 wr_en", 64'(wr_en), 0);
      chk("R10 rsp_rdata", 64'(rsp_rdata), 0);
      rst_n = 1;
      // R6: swap form in machine mode
      req(12'h340, 2'd3, 32'h1234_5678, 32'hFFFF_FFFF, 1, 0, 0, 2'd1, 32'hAAAA_5555);
      // R6: set form and clear form
      req(12'h340, 2'd3, 32'hFFFF_FFFF, 32'h0000_00F0, 1, 0, 0, 2'd1, 32'h0000_0F0F);
      req(12'h340, 2'd3, 32'h0, 32'h0000_0F00, 1, 0, 0, 2'd1, 32'h0000_0F0F);
      // R1: user touches machine and supervisor space; supervisor touches machine
      req(12'h300, 2'd0, 32'h1, 32'h1, 1, 0, 0, 2'd1, 32'h7);
      req(12'h100, 2'd0, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h7);
      req(12'h305, 2'd1, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h7);
      req(12'h140, 2'd1, 32'h9, 32'hF, 1, 0, 0, 2'd1, 32'h7);
      // R2: read-only space read ok, write refused
      req(12'hF14, 2'd3, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h42);
      req(12'hF14, 2'd3, 32'h0, 32'h1, 1, 0, 0, 2'd1, 32'h42);
      // R3: counter chain
      m_cnt_en = 32'h0000_0005; s_cnt_en = 32'h0000_0001;
      req(12'hC00, 2'd0, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h11);
      req(12'hC02, 2'd0, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h22);
      req(12'hC02, 2'd1, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h22);
      req(12'hC01, 2'd1, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h33);
      req(12'hC81, 2'd3, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h44);
      req(12'hC9F, 2'd0, 32'h0, 32'h0, 1, 0, 0, 2'd1, 32'h55);
      // R4: floating-point gate and debug bypass
      req(12'h003, 2'd0, 32'h0, 32'h0, 1, 1, 0, 2'd0, 32'h66);
      req(12'h003, 2'd0, 32'h0, 32'h0, 1, 1, 1, 2'd0, 32'h66);
      // R5: legal FP write marks dirty; zero mask does not (R7)
      req(12'h001, 2'd0, 32'h1F, 32'hFFFF_FFFF, 1, 1, 0, 2'd1, 32'h0);
      req(12'h001, 2'd0, 32'h1F, 32'h0, 1, 1, 0, 2'd1, 32'h3);
      // R8: absent register
      req(12'h7C0, 2'd3, 32'h0, 32'h0, 0, 0, 0, 2'd1, 32'h99);
      // R9: idle cycle
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [11:0] ad;
         ad = 12'($urandom);
         if (i % 3 == 0) ad = {7'($urandom_range(0, 1) ? 7'h60 : 7'h64), 5'($urandom)};
         m_cnt_en = $urandom; s_cnt_en = $urandom;
         req(ad, 2'($urandom), $urandom, (i % 4 == 0) ? 32'h0 : $urandom,
             1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom),
             2'($urandom), $urandom);
         if (i % 17 == 0) begin @(negedge clk); req_valid = 0; end
      end
      @(negedge clk); req_valid = 0;
      repeat (2) @(negedge clk);
      running = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule